// File: doc/BRIEF.md
# DMA Master Control and Status Register

This block is the shared 8-bit control and status register of a multi-channel DMA controller. It holds one master enable bit and two sticky error flags: one records an address error reported by the controller and one records an NMI event. From these bits and each channel's own enable and transfer-end bits, it produces a per-channel permit signal that the channel engines use to decide whether they may start a transfer unit.

Software reaches the register through a plain strobe interface. This interface has a read strobe, a write strobe and write data, and the read data always shows the current register value. The error flags follow a read-then-clear discipline. A flag drops only when a write of 0 follows a read that returned 1. Writing 1 to a flag does nothing.

When an NMI arrives while a transfer unit is running, that unit is allowed to finish. The permits stay high until the end-of-unit pulse. After that pulse, no further units start. An address error removes the permits at once.

Top module: `dma_master_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, the read data is 0x00 and every permit is 0. Asserting the active-low reset clears the state immediately, without waiting for a clock edge.
- R2: The register layout is as follows: bit 0 is the master enable, bit 1 is the NMI flag and bit 2 is the address-error flag. Bits 7..3 always read 0, and the write data for those bits is discarded.
- R3: The master enable is an ordinary read/write bit. A write loads it from write-data bit 0.
- R4: The permit for channel i is 1 exactly when all of the following hold: the master enable is 1, channel i's enable is 1, channel i's transfer-end bit is 0, the address-error flag is 0, and no NMI halt is in force.
- R5: An address-error pulse sets the address-error flag at the next clock edge. From that cycle on, every permit is 0.
- R6: An NMI pulse sets the NMI flag at the next clock edge, even when the master enable is 0 and no transfer is active.
- R7: A write of 0 to a flag has no effect unless an earlier read strobe returned that flag as 1. A read that returns 1 arms that flag for clearing.
- R8: A write of 0 to an armed flag clears the flag and disarms it, so any later clear needs a new read. A write of 1 to a flag has no effect.
- R9: If a set event and a qualifying clearing write occur in the same cycle, the set event wins. The flag stays 1 and remains armed.
- R10: While the NMI flag is 1 and some permit is high, the permits stay high until a clock edge at which the end-of-unit input is 1. They are 0 from the following cycle on. If no permit is high, the halt takes hold at the next edge. The halt lifts one cycle after the NMI flag reads 0.
- R11: Clearing the master enable drops every permit in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe; arms any flag currently reading 1 |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| addr_err_i | input | 1 | Address-error event pulse |
| nmi_i | input | 1 | NMI event pulse |
| unit_end_i | input | 1 | End of the current transfer unit |
| ch_enable_i | input | NUM_CH | Per-channel enable bits |
| ch_tend_i | input | NUM_CH | Per-channel transfer-end bits |
| rd_data_o | output | 8 | Current register value |
| ch_permit_o | output | NUM_CH | Per-channel transfer permit |

## Verification
A wrong arm latch shows up at the read data one cycle after the clearing write. In that case a flag either fails to fall or falls without a prior read. A stuck flag or halt register shows up as a permit pattern that is wrong in the same cycle, because the permits are a combinational function of the registers and the channel inputs. The NMI halt is the only delayed effect. A fault there appears as permits that drop one edge too early or too late around the end-of-unit pulse. The sequences therefore step through that pulse cycle by cycle.

// File: rtl/mctl_pkg.sv
package mctl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ENA_BIT = 0;
  localparam int unsigned NMI_BIT = 1;
  localparam int unsigned AER_BIT = 2;
  localparam int unsigned DEF_W   = 3;
endpackage

// File: rtl/mctl_rst_sync.sv
module mctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mctl_flag.sv
module mctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr_req;

  assign clr_req = wr_i && !wr_bit_i && arm_q;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (rd_i && flag_q) arm_d = 1'b1;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  // R9: a set event always leaves the flag at 1
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R7: a fall needs a prior arming read and a write of 0
  p_clear_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q && wr_i && !wr_bit_i));
  // R8: a write of 1 never clears the flag
  p_write_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && (!wr_i || wr_bit_i)) |=> flag_q);
endmodule

// File: rtl/mctl_nmi_hold.sv
module mctl_nmi_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_flag_i,
  input  logic busy_i,
  input  logic unit_end_i,
  output logic halt_o
);
  logic halt_q, halt_d;

  always_comb begin
    halt_d = nmi_flag_i && (halt_q || unit_end_i || !busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  assign halt_o = halt_q;

  // R10: an in-flight unit is not cut short before its end pulse
  p_unit_finishes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag_i && busy_i && !unit_end_i && !halt_q) |=> !halt_q);
  // R10: the halt never outlives a cleared flag by more than a cycle
  p_halt_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_flag_i |=> !halt_q);
endmodule

// File: rtl/mctl_gate.sv
module mctl_gate #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              master_en_i,
  input  logic              addr_err_i,
  input  logic              halt_i,
  input  logic [NUM_CH-1:0] ch_enable_i,
  input  logic [NUM_CH-1:0] ch_tend_i,
  output logic [NUM_CH-1:0] permit_o
);
  logic global_ok;

  assign global_ok = master_en_i && !addr_err_i && !halt_i;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign permit_o[i] = global_ok && ch_enable_i[i] && !ch_tend_i[i];
  end
endmodule

// File: rtl/dma_master_ctl.sv
module dma_master_ctl
  import mctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              addr_err_i,
  input  logic              nmi_i,
  input  logic              unit_end_i,
  input  logic [NUM_CH-1:0] ch_enable_i,
  input  logic [NUM_CH-1:0] ch_tend_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] ch_permit_o
);
  logic rst_sync_n;
  logic ena_q, ena_d;
  logic nmi_flag, aer_flag, halt;
  logic busy;

  mctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    ena_d = ena_q;
    if (wr_en_i) ena_d = wr_data_i[ENA_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ena_q <= 1'b0;
    else             ena_q <= ena_d;
  end

  mctl_flag u_nmi_flag (
    .clk(clk), .rst_n(rst_sync_n), .set_i(nmi_i), .rd_i(rd_en_i),
    .wr_i(wr_en_i), .wr_bit_i(wr_data_i[NMI_BIT]), .flag_o(nmi_flag)
  );

  mctl_flag u_aer_flag (
    .clk(clk), .rst_n(rst_sync_n), .set_i(addr_err_i), .rd_i(rd_en_i),
    .wr_i(wr_en_i), .wr_bit_i(wr_data_i[AER_BIT]), .flag_o(aer_flag)
  );

  assign busy = |ch_permit_o;

  mctl_nmi_hold u_hold (
    .clk(clk), .rst_n(rst_sync_n), .nmi_flag_i(nmi_flag), .busy_i(busy),
    .unit_end_i(unit_end_i), .halt_o(halt)
  );

  mctl_gate #(.NUM_CH(NUM_CH)) u_gate (
    .master_en_i(ena_q), .addr_err_i(aer_flag), .halt_i(halt),
    .ch_enable_i(ch_enable_i), .ch_tend_i(ch_tend_i), .permit_o(ch_permit_o)
  );

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[ENA_BIT] = ena_q;
    rd_data_o[NMI_BIT] = nmi_flag;
    rd_data_o[AER_BIT] = aer_flag;
  end

  // R2: reserved bits never read back as 1
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data_o[REG_W-1:DEF_W] == '0);
  // R5: an address error blocks every channel
  p_aer_blocks_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data_o[AER_BIT] |-> (ch_permit_o == '0));
  // R11: a write clearing the enable drops all permits next cycle
  p_disable_drops_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && !wr_data_i[ENA_BIT]) |=> (ch_permit_o == '0));
  // R4: a permit implies its own channel qualifiers
  p_permit_qual_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((ch_permit_o & ~(ch_enable_i & ~ch_tend_i)) == '0));
endmodule

// File: tb/dma_master_ctl_test.sv
module dma_master_ctl_test;
  localparam int NCH = 4;
  localparam int NV  = 29;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]     wr_data = '0;
  logic           aerr = 1'b0, nmi = 1'b0, uend = 1'b0;
  logic [NCH-1:0] ch_en = '0, ch_te = '0;
  logic [7:0]     rd_data;
  logic [NCH-1:0] permit;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_master_ctl #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .addr_err_i(aerr), .nmi_i(nmi),
    .unit_end_i(uend), .ch_enable_i(ch_en), .ch_tend_i(ch_te),
    .rd_data_o(rd_data), .ch_permit_o(permit)
  );

  // Fields: rd, wr, wdata[8], aerr, nmi, uend, en[4], tend[4], exp_rd[8], exp_permit[4]
  localparam logic [32:0] VEC [NV] = '{
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 0  R3 set enable
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h5,8'h01,4'hA}, // 1  R4 tend masks
    {1'b0,1'b1,8'hFF,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 2  R2 upper bits, R8 write 1
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 3  R5 address error
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 4  R7 unarmed clear
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 5  R7 arming read
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 6  R8 armed clear
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 7  R8 repeat write
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 8  R5 set again
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 9  R8 disarmed
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 10 R9 arm
    {1'b0,1'b1,8'h01,1'b1,1'b0,1'b0,4'hF,4'h0,8'h05,4'h0}, // 11 R9 set beats clear
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 12 R9 still armed
    {1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h00,4'h0}, // 13 R11 disable
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,4'hF,4'h0,8'h02,4'h0}, // 14 R6 NMI while idle
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h02,4'h0}, // 15 R7 arm NMI flag
    {1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h00,4'h0}, // 16 R8 clear NMI flag
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 17 R3 re-enable
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'h3,4'h0,8'h01,4'h3}, // 18 R4 partial enables
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,4'hF,4'h0,8'h03,4'hF}, // 19 R10 NMI in flight
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h03,4'hF}, // 20 R10 unit continues
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'hF,4'h0,8'h03,4'h0}, // 21 R10 end of unit
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h03,4'h0}, // 22 R10 halted
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h03,4'h0}, // 23 R7 arm
    {1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'h0}, // 24 R10 halt lingers
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h01,4'hF}, // 25 R10 resumed
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b1,4'hF,4'h0,8'h03,4'hF}, // 26 R10 end with NMI
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'hF,4'h0,8'h03,4'hF}, // 27 R10 next unit runs
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'hF,4'h0,8'h03,4'h0}  // 28 R10 halted
  };

  task automatic check(input string req, input logic [7:0] rd_exp,
                       input logic [NCH-1:0] pm_exp);
    checks++;
    if (rd_data !== rd_exp) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", req, rd_data, rd_exp);
    end
    if (permit !== pm_exp) begin
      errors++;
      $display("FAIL %s permit actual %b expected %b", req, permit, pm_exp);
    end
  endtask

  task automatic idle_inputs();
    rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    aerr = 1'b0; nmi = 1'b0; uend = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    ch_en = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h00, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 8'h00, 4'h0);

    for (int k = 0; k < NV; k++) begin
      rd_en   = VEC[k][32];
      wr_en   = VEC[k][31];
      wr_data = VEC[k][30:23];
      aerr    = VEC[k][22];
      nmi     = VEC[k][21];
      uend    = VEC[k][20];
      ch_en   = VEC[k][19:16];
      ch_te   = VEC[k][15:12];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vector %0d", k), VEC[k][11:4], VEC[k][3:0]);
    end
    idle_inputs();

    // R1: asynchronous reset while enabled and with a flag set
    @(negedge clk);
    aerr = 1'b0; nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", 8'h00, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 post async", 8'h00, 4'h0);

    // R2: writing only reserved bits changes nothing
    wr_en = 1'b1; wr_data = 8'hF8;
    @(negedge clk);
    idle_inputs();
    check("R2 reserved write", 8'h00, 4'h0);

    // R6 and R10: NMI with no permit halts at once
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk);
    idle_inputs();
    check("R10 halt without busy", 8'h03, 4'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule